// File: doc/BRIEF.md
# Flash Programming Control Unlock Unit

This unit sits on the special-function-register byte bus of a microcontroller core and guards the register that controls in-system flash programming. The control register is read-only until software writes a two-byte key to a separate key register: 87h first, then 59h. Once the key is accepted, software may set the programming-mode request bit. The switch from the 64 KB application code bank to the 4 KB loader code bank does not happen at that write. It happens at the next wake-up from idle, and the program counter is cleared in the same step.

Writing a control value with bits 0, 1 and 7 all set, while writes are unlocked, raises a one-cycle CPU software reset. The same event returns the unit to its reset state and selects the application bank again. Four further byte registers hold the flash target address (high and low bytes), the program data and the flash operation code. They drive the flash sequencer directly.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, the application bank is selected (`loader_bank_o`=0), both pulses are low, the flash address, data and command outputs are 0, the control register reads 00h, and control writes are locked.
- R2: Register offsets on `sfr_addr_i` are: key 0, control 1, address low 2, address high 3, data 4, command 5. While locked, a write to the control register leaves it unchanged. A read of the control register always returns its current contents.
- R3: A write of 87h to the key register followed by a write of 59h to the key register unlocks control writes. Writes to other registers between the two key writes do not break the sequence.
- R4: Any key-register write that does not complete the sequence locks control writes, including one made while unlocked. A write of 87h always starts a fresh attempt, so 87h, 87h, 59h unlocks.
- R5: With control bit 0 set, an idle entry strobe followed by a wake-up strobe selects the loader bank. In the cycle after the wake-up is sampled, `loader_bank_o` rises and `pc_clear_o` is high for exactly one cycle.
- R6: A wake-up with no preceding idle entry has no effect. A wake-up after idle with control bit 0 clear leaves the bank select unchanged and gives no `pc_clear_o` pulse.
- R7: While unlocked, a control write with bits 0, 1 and 7 all set makes `sw_reset_o` high for exactly the next cycle. It returns the control register, the lock state, the bank select and the flash byte registers to their reset values, and the written value is not stored.
- R8: The address high/low, data and command registers accept writes whether or not control writes are unlocked. They read back their contents and drive `flash_addr_o` = {high, low}, `flash_data_o` and `flash_cmd_o`.
- R9: If a software-reset control write and a wake-up that would select the loader bank are sampled in the same cycle, the software reset wins: the application bank stays selected and `pc_clear_o` stays low.
- R10: `sfr_rdata_o` is 00h when `sfr_re_i` is low, when the key register is read, and when an unmapped offset is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_re_i | input | 1 | Register read strobe |
| sfr_addr_i | input | 3 | Register offset |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data (combinational) |
| idle_enter_i | input | 1 | CPU enters idle mode |
| wake_i | input | 1 | CPU wakes from idle |
| loader_bank_o | output | 1 | 1 = loader bank, 0 = application bank |
| pc_clear_o | output | 1 | One-cycle program-counter clear |
| sw_reset_o | output | 1 | One-cycle CPU software reset |
| flash_addr_o | output | 16 | Flash target address |
| flash_data_o | output | 8 | Flash program data |
| flash_cmd_o | output | 8 | Flash operation code |

## Verification
A software-reset write to the control register and a wake-up from idle can be sampled in the same cycle. One would clear the bank select and the other would set it. The bench provokes this by leaving the programming request pending in idle, then driving the reset-pattern control write and the wake strobe on the same clock edge. It then expects `sw_reset_o` high, `pc_clear_o` low and the application bank still selected in the next cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  parameter int unsigned SFR_AW = 3;
  parameter int unsigned SFR_DW = 8;

  parameter logic [SFR_AW-1:0] OFF_KEY     = 3'd0;
  parameter logic [SFR_AW-1:0] OFF_CTRL    = 3'd1;
  parameter logic [SFR_AW-1:0] OFF_ADDR_LO = 3'd2;
  parameter logic [SFR_AW-1:0] OFF_ADDR_HI = 3'd3;
  parameter logic [SFR_AW-1:0] OFF_DATA    = 3'd4;
  parameter logic [SFR_AW-1:0] OFF_CMD     = 3'd5;

  // byte register slots, ordered from OFF_ADDR_LO upward
  parameter int unsigned NUM_BYTE_REGS = 4;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/fpc_key_fsm.sv
module fpc_key_fsm
  import fpc_pkg::*;
#(
  parameter int unsigned     DW         = 8,
  parameter logic [DW-1:0]   KEY_FIRST  = 8'h87,
  parameter logic [DW-1:0]   KEY_SECOND = 8'h59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          key_we_i,
  input  logic [DW-1:0] key_wdata_i,
  output logic          unlocked_o
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      if (state_q == KEY_HALF && key_wdata_i == KEY_SECOND) state_d = KEY_OPEN;
      else if (key_wdata_i == KEY_FIRST)                    state_d = KEY_HALF;
      else                                                  state_d = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= KEY_LOCKED;
    else if (clr_i) state_q <= KEY_LOCKED;
    else            state_q <= state_d;
  end

  assign unlocked_o = (state_q == KEY_OPEN);

  AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(key_we_i && key_wdata_i == KEY_SECOND)); // R3

  AST_BAD_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_wdata_i != KEY_SECOND) |=> !unlocked_o); // R4

endmodule

// File: rtl/fpc_mode_ctrl.sv
module fpc_mode_ctrl #(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   PROG_BIT = 0,
  parameter logic [DW-1:0] RST_MASK = 8'h83
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] ctrl_wdata_i,
  input  logic          unlocked_i,
  input  logic          idle_enter_i,
  input  logic          wake_i,
  output logic [DW-1:0] ctrl_o,
  output logic          loader_bank_o,
  output logic          pc_clear_o,
  output logic          sw_reset_o,
  output logic          swrst_req_o
);

  logic [DW-1:0] ctrl_q;
  logic          idle_q, bank_q, pc_clear_q, sw_reset_q;
  logic          ctrl_write;

  assign ctrl_write  = ctrl_we_i && unlocked_i;
  assign swrst_req_o = ctrl_write && ((ctrl_wdata_i & RST_MASK) == RST_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      idle_q     <= 1'b0;
      bank_q     <= 1'b0;
      pc_clear_q <= 1'b0;
      sw_reset_q <= 1'b0;
    end else if (swrst_req_o) begin
      // software reset outranks every other update this cycle
      ctrl_q     <= '0;
      idle_q     <= 1'b0;
      bank_q     <= 1'b0;
      pc_clear_q <= 1'b0;
      sw_reset_q <= 1'b1;
    end else begin
      sw_reset_q <= 1'b0;
      pc_clear_q <= 1'b0;
      if (ctrl_write) ctrl_q <= ctrl_wdata_i;
      if (wake_i && idle_q) begin
        idle_q <= 1'b0;
        if (ctrl_q[PROG_BIT] && !bank_q) begin
          bank_q     <= 1'b1;
          pc_clear_q <= 1'b1;
        end
      end
      if (idle_enter_i) idle_q <= 1'b1;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign loader_bank_o = bank_q;
  assign pc_clear_o    = pc_clear_q;
  assign sw_reset_o    = sw_reset_q;

  AST_CTRL_HELD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !unlocked_i) |=> $stable(ctrl_o)); // R2

  AST_PC_CLEAR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_clear_o |-> (loader_bank_o && $rose(loader_bank_o))); // R5

  AST_NO_REQ_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !ctrl_o[PROG_BIT] && !swrst_req_o) |=> $stable(loader_bank_o)); // R6

  AST_SWRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_o |=> !sw_reset_o); // R7

  AST_SWRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_o |-> (!loader_bank_o && ctrl_o == '0)); // R7

  AST_SWRST_BEATS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swrst_req_o && wake_i) |=> (!pc_clear_o && !loader_bank_o)); // R9

endmodule

// File: rtl/fpc_byte_regs.sv
module fpc_byte_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic [N-1:0]          we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N-1:0][DW-1:0]  q_o
);

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (clr_i)  q <= '0;
      else if (we_i[g]) q <= wdata_i;
    end
    assign q_o[g] = q;

    AST_BYTE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[g] && !clr_i) |=> (q_o[g] == $past(wdata_i))); // R8
  end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter logic [SFR_DW-1:0] KEY_FIRST  = 8'h87,
  parameter logic [SFR_DW-1:0] KEY_SECOND = 8'h59,
  parameter logic [SFR_DW-1:0] RST_MASK   = 8'h83,
  parameter int unsigned       PROG_BIT   = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sfr_we_i,
  input  logic                sfr_re_i,
  input  logic [SFR_AW-1:0]   sfr_addr_i,
  input  logic [SFR_DW-1:0]   sfr_wdata_i,
  output logic [SFR_DW-1:0]   sfr_rdata_o,
  input  logic                idle_enter_i,
  input  logic                wake_i,
  output logic                loader_bank_o,
  output logic                pc_clear_o,
  output logic                sw_reset_o,
  output logic [2*SFR_DW-1:0] flash_addr_o,
  output logic [SFR_DW-1:0]   flash_data_o,
  output logic [SFR_DW-1:0]   flash_cmd_o
);

  localparam int unsigned NB = NUM_BYTE_REGS;

  logic                        key_we, ctrl_we, unlocked, swrst_req;
  logic [SFR_DW-1:0]           ctrl;
  logic [NB-1:0]               byte_we;
  logic [NB-1:0][SFR_DW-1:0]   byte_q;

  assign key_we  = sfr_we_i && (sfr_addr_i == OFF_KEY);
  assign ctrl_we = sfr_we_i && (sfr_addr_i == OFF_CTRL);

  for (genvar g = 0; g < NB; g++) begin : g_dec
    assign byte_we[g] = sfr_we_i && (sfr_addr_i == OFF_ADDR_LO + SFR_AW'(g));
  end

  fpc_key_fsm #(
    .DW(SFR_DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk_i, .rst_ni,
    .clr_i       (swrst_req),
    .key_we_i    (key_we),
    .key_wdata_i (sfr_wdata_i),
    .unlocked_o  (unlocked)
  );

  fpc_mode_ctrl #(
    .DW(SFR_DW), .PROG_BIT(PROG_BIT), .RST_MASK(RST_MASK)
  ) u_mode (
    .clk_i, .rst_ni,
    .ctrl_we_i     (ctrl_we),
    .ctrl_wdata_i  (sfr_wdata_i),
    .unlocked_i    (unlocked),
    .idle_enter_i,
    .wake_i,
    .ctrl_o        (ctrl),
    .loader_bank_o,
    .pc_clear_o,
    .sw_reset_o,
    .swrst_req_o   (swrst_req)
  );

  fpc_byte_regs #(.DW(SFR_DW), .N(NB)) u_bytes (
    .clk_i, .rst_ni,
    .clr_i   (swrst_req),
    .we_i    (byte_we),
    .wdata_i (sfr_wdata_i),
    .q_o     (byte_q)
  );

  assign flash_addr_o = {byte_q[OFF_ADDR_HI - OFF_ADDR_LO], byte_q[0]};
  assign flash_data_o = byte_q[OFF_DATA - OFF_ADDR_LO];
  assign flash_cmd_o  = byte_q[OFF_CMD - OFF_ADDR_LO];

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_re_i) begin
      if (sfr_addr_i == OFF_CTRL) sfr_rdata_o = ctrl;
      for (int i = 0; i < NB; i++)
        if (sfr_addr_i == OFF_ADDR_LO + SFR_AW'(i)) sfr_rdata_o = byte_q[i];
    end
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sfr_re_i || sfr_addr_i == OFF_KEY) |-> (sfr_rdata_o == '0)); // R10

endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 0, re = 0, idle_en = 0, wake = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bank, pcc, swr;
  logic [15:0] faddr;
  logic [7:0]  fdata, fcmd;

  int n_tests = 0, n_fail = 0;

  localparam logic [2:0] A_KEY = 0, A_CTRL = 1, A_LO = 2, A_HI = 3, A_DAT = 4, A_CMD = 5;

  always #2 clk = ~clk;

  flash_prog_ctrl u_flash_prog_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(we), .sfr_re_i(re), .sfr_addr_i(addr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .idle_enter_i(idle_en), .wake_i(wake),
    .loader_bank_o(bank), .pc_clear_o(pcc), .sw_reset_o(swr),
    .flash_addr_o(faddr), .flash_data_o(fdata), .flash_cmd_o(fcmd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1; #1 d = rdata; re = 0;
  endtask

  task automatic go_idle();
    @(negedge clk); idle_en = 1; @(negedge clk); idle_en = 0;
  endtask

  task automatic do_wake();
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'h87); wr(A_KEY, 8'h59);
  endtask

  task automatic soft_reset();
    unlock(); wr(A_CTRL, 8'h83);
  endtask

  // tries a control write that flips bit 4 and reports whether it landed
  task automatic probe_open(output bit open);
    logic [7:0] old_v, new_v, got;
    rd(A_CTRL, old_v);
    new_v = old_v ^ 8'h10;
    wr(A_CTRL, new_v);
    rd(A_CTRL, got);
    open = (got == new_v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 bank", bank, 0); chk("R1 pc_clear", pcc, 0); chk("R1 sw_reset", swr, 0);
    chk("R1 faddr", faddr, 0); chk("R1 fdata", fdata, 0); chk("R1 fcmd", fcmd, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr(A_CTRL, 8'h01); rd(A_CTRL, v); chk("R2 locked write ignored", v, 0);
    unlock(); wr(A_CTRL, 8'h24); wr(A_KEY, 8'h00);
    rd(A_CTRL, v); chk("R2 read while locked", v, 8'h24);
  endtask

  task automatic t_keys();
    bit o;
    wr(A_KEY, 8'h87); wr(A_LO, 8'h11); wr(A_KEY, 8'h59);
    probe_open(o); chk("R3 unlock across other write", o, 1);
    wr(A_KEY, 8'h33); probe_open(o); chk("R4 bad key closes open", o, 0);
    wr(A_KEY, 8'h87); wr(A_KEY, 8'h12); wr(A_KEY, 8'h59);
    probe_open(o); chk("R4 wrong second byte", o, 0);
    wr(A_KEY, 8'h87); wr(A_KEY, 8'h87); wr(A_KEY, 8'h59);
    probe_open(o); chk("R4 87 restarts", o, 1);
    wr(A_KEY, 8'h59); probe_open(o); chk("R4 lone 59", o, 0);
    wr(A_KEY, 8'h87); probe_open(o); chk("R4 87 while open locks", o, 0);
  endtask

  task automatic t_prog();
    soft_reset(); @(negedge clk);
    unlock(); wr(A_CTRL, 8'h01);
    do_wake(); chk("R6 wake without idle", bank, 0);
    chk("R6 no pc_clear without idle", pcc, 0);
    go_idle(); chk("R5 no switch before wake", bank, 0);
    do_wake(); chk("R5 loader bank", bank, 1); chk("R5 pc_clear pulse", pcc, 1);
    @(negedge clk); chk("R5 pc_clear one cycle", pcc, 0); chk("R5 bank held", bank, 1);
  endtask

  task automatic t_no_req();
    soft_reset(); @(negedge clk);
    unlock(); wr(A_CTRL, 8'h02);
    go_idle(); do_wake();
    chk("R6 no request keeps bank", bank, 0); chk("R6 no request no pulse", pcc, 0);
  endtask

  task automatic t_swreset();
    logic [7:0] v; bit o;
    soft_reset(); @(negedge clk);
    unlock(); wr(A_CTRL, 8'h01); go_idle(); do_wake();
    wr(A_HI, 8'hA5);
    unlock(); wr(A_CTRL, 8'h83);
    chk("R7 sw_reset high", swr, 1); chk("R7 bank to app", bank, 0);
    chk("R7 flash regs cleared", faddr, 0);
    @(negedge clk); chk("R7 sw_reset one cycle", swr, 0);
    rd(A_CTRL, v); chk("R7 ctrl cleared", v, 0);
    probe_open(o); chk("R7 relocked", o, 0);
    wr(A_CTRL, 8'h83); chk("R7 locked pattern no reset", swr, 0);
  endtask

  task automatic t_flash();
    logic [7:0] v;
    wr(A_HI, 8'hA5); wr(A_LO, 8'h3C); wr(A_DAT, 8'h5E); wr(A_CMD, 8'h21);
    chk("R8 address", faddr, 16'hA53C); chk("R8 data", fdata, 8'h5E); chk("R8 cmd", fcmd, 8'h21);
    rd(A_HI, v); chk("R8 read hi", v, 8'hA5);
    rd(A_CMD, v); chk("R8 read cmd", v, 8'h21);
    rd(A_KEY, v); chk("R10 key reads zero", v, 0);
    rd(3'd7, v); chk("R10 unmapped zero", v, 0);
    #1 chk("R10 no read zero", rdata, 0);
  endtask

  task automatic t_collide();
    soft_reset(); @(negedge clk);
    unlock(); wr(A_CTRL, 8'h01); go_idle();
    @(negedge clk); addr = A_CTRL; wdata = 8'h83; we = 1; wake = 1;
    @(negedge clk); we = 0; wake = 0;
    chk("R9 sw_reset wins", swr, 1); chk("R9 no pc_clear", pcc, 0);
    chk("R9 bank stays app", bank, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_keys();
    t_prog();
    t_no_req();
    t_swreset();
    t_flash();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule